// File: doc/BRIEF.md
# Reduced-ISA 32-bit Processor Core

This block is a small in-order 32-bit processor that runs an eleven-instruction subset of a classic load/store instruction set. It completes one instruction per clock cycle: it fetches from an instruction memory array, decodes, reads two operands from a 32 x 32-bit register file, runs the ALU, accesses a data memory array and writes the result back. The core has no pipeline, no hazard logic, no exceptions and no caches. Opcodes and function codes outside the subset retire as no-ops.

Both memory arrays have write ports at the block edge. The environment uses them to preload a program and its data while reset is held. After reset is released the core runs until it decodes a halt instruction. It then raises a halted flag and freezes. A debug port reads any register and any data memory word at any time.

Top module: `rcore_top`

## Requirements
- R1: While rst_ni is low, the PC is 0, halted_o is 0 and every register reads 0. After rst_ni is released, the first instruction executed is the word at byte address 0. The memory contents survive reset.
- R2: ADD (opcode 0x00, func 0x020) and SUB (opcode 0x00, func 0x022) write rs+rt and rs-rt to rd, wrapping modulo 2^32 without any trap. The R-type fields are opcode[31:26], rs[25:21], rt[20:16], rd[15:11] and func[10:0].
- R3: AND (func 0x024) and OR (func 0x025) write the bitwise AND and the bitwise OR of rs and rt to rd.
- R4: SLL (func 0x004) and SRL (func 0x006) shift rs by the value in bits [4:0] of rt and write the result to rd. SRL fills with zeros.
- R5: ADDI (opcode 0x08) writes rs plus the sign-extended imm[15:0] to rt.
- R6: SW (opcode 0x2B) stores rt at byte address rs+sext(imm). LW (opcode 0x23) loads the word at that address into rt. The address selects the word whose index is address[DMEM_AW+1:2].
- R7: BEQZ (opcode 0x04) sets the next PC to PC+4+sext(imm) when rs equals 0 and to PC+4 otherwise. The immediate is a byte offset and is not shifted.
- R8: Writes to register 0 are discarded, and register 0 always reads 0.
- R9: HALT (opcode 0x3F) raises halted_o at the clock edge that executes it. From then on no register, memory word or PC changes until reset.
- R10: Any other opcode, and any R-type func value other than the six listed, compared over all 11 bits, changes no register or memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction memory preload write enable |
| imem_waddr_i | input | IMEM_AW | Instruction memory preload word index |
| imem_wdata_i | input | 32 | Instruction memory preload data |
| dmem_we_i | input | 1 | Data memory preload write enable (has priority over core stores) |
| dmem_waddr_i | input | DMEM_AW | Data memory preload word index |
| dmem_wdata_i | input | 32 | Data memory preload data |
| dbg_reg_i | input | 5 | Debug register index |
| dbg_reg_o | output | 32 | Debug register value |
| dbg_mem_i | input | DMEM_AW | Debug data memory word index |
| dbg_mem_o | output | 32 | Debug data memory word |
| halted_o | output | 1 | Core has executed HALT |

## Verification
The main program mixes arithmetic on operands whose signed add or subtract overflows. This separates true modulo-2^32 wrap from saturation or trapping. The shift amounts come from registers that have high bits set, so that using bits [4:0] can be told apart from using the whole word. A func value whose low six bits alone match ADD shows whether all 11 bits are decoded. Two branches, one taken and one not, plus a counted loop with a negative offset, expose a left-shifted or wrongly signed offset because the wrong code would land on a different instruction. Short directed programs after re-reset measure the exact cycle when halted_o rises and confirm that memory survives reset while registers clear.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQZ  = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_HALT  = 6'h3F;

  localparam logic [10:0] FN_SLL = 11'h004;
  localparam logic [10:0] FN_SRL = 11'h006;
  localparam logic [10:0] FN_ADD = 11'h020;
  localparam logic [10:0] FN_SUB = 11'h022;
  localparam logic [10:0] FN_AND = 11'h024;
  localparam logic [10:0] FN_OR  = 11'h025;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLL,
    ALU_SRL,
    ALU_AND,
    ALU_OR
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    use_imm;
    logic    mem_we;
    logic    mem_to_rf;
    logic    branch;
    logic    halt;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/rcore_mem.sv
module rcore_mem #(
  parameter int unsigned AW  = 6,
  parameter int unsigned W   = 32,
  parameter int unsigned NRP = 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i [NRP],
  output logic [W-1:0]  rdata_o [NRP]
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [$clog2(NREG)-1:0] ra_i,
  input  logic [$clog2(NREG)-1:0] rb_i,
  input  logic [$clog2(NREG)-1:0] rc_i,
  output logic [W-1:0]            ra_o,
  output logic [W-1:0]            rb_o,
  output logic [W-1:0]            rc_o
);

  localparam int unsigned AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             regs[g] <= '0;
        else if (we_i && (waddr_i == AW'(g)))    regs[g] <= wdata_i;
      end
    end
  end

  assign ra_o = regs[ra_i];
  assign rb_o = regs[rb_i];
  assign rc_o = regs[rc_i];

  // written value lands only at its own index
  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && rc_i == waddr_i) |=> (rc_o == $past(wdata_i) || rc_i != $past(rc_i)));

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  localparam int unsigned SHW = $clog2(W);

  logic [SHW-1:0] shamt;
  assign shamt = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLL: y_o = a_i << shamt;
      ALU_SRL: y_o = a_i >> shamt;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end

endmodule

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [31:0]  instr_i,
  output ctrl_t        ctrl_o,
  output logic [4:0]   rs_o,
  output logic [4:0]   rt_o,
  output logic [4:0]   rd_o,
  output logic [W-1:0] imm_o
);

  logic [5:0]  opcode;
  logic [10:0] func;

  assign opcode = instr_i[31:26];
  assign func   = instr_i[10:0];
  assign rs_o   = instr_i[25:21];
  assign rt_o   = instr_i[20:16];
  assign rd_o   = instr_i[15:11];
  assign imm_o  = {{(W-16){instr_i[15]}}, instr_i[15:0]};

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        case (func)
          FN_ADD: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
          FN_SLL: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SLL; end
          FN_SRL: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SRL; end
          FN_AND: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
          FN_OR:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
          default: ;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_LW: begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.use_imm   = 1'b1;
        ctrl_o.mem_to_rf = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_BEQZ: ctrl_o.branch = 1'b1;
      OP_HALT: ctrl_o.halt   = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int unsigned IMEM_AW = 6,
  parameter int unsigned DMEM_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_waddr_i,
  input  logic [31:0]        imem_wdata_i,
  input  logic               dmem_we_i,
  input  logic [DMEM_AW-1:0] dmem_waddr_i,
  input  logic [31:0]        dmem_wdata_i,
  input  logic [4:0]         dbg_reg_i,
  output logic [31:0]        dbg_reg_o,
  input  logic [DMEM_AW-1:0] dbg_mem_i,
  output logic [31:0]        dbg_mem_o,
  output logic               halted_o
);

  localparam int unsigned NREG = 32;

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next;
  logic            halted_q;
  logic            run;

  logic [31:0]     instr;
  ctrl_t           ctrl;
  logic [4:0]      rs, rt, rd;
  logic [XLEN-1:0] imm_ext;

  logic [XLEN-1:0] rs_val, rt_val, op_b, alu_res, wb_data;
  logic [4:0]      rf_waddr;
  logic            rf_we, core_st, take;

  logic [IMEM_AW-1:0] im_ra [1];
  logic [31:0]        im_rd [1];
  logic [DMEM_AW-1:0] dm_ra [2];
  logic [31:0]        dm_rd [2];
  logic               dm_we;
  logic [DMEM_AW-1:0] dm_wa;
  logic [31:0]        dm_wd;

  assign run = rst_ni & ~halted_q;

  // fetch
  assign im_ra[0] = pc_q[IMEM_AW+1:2];
  assign instr    = im_rd[0];

  rcore_mem #(.AW(IMEM_AW), .W(32), .NRP(1)) i_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (im_ra),
    .rdata_o (im_rd)
  );

  rcore_decode #(.W(XLEN)) i_decode (
    .instr_i (instr),
    .ctrl_o  (ctrl),
    .rs_o    (rs),
    .rt_o    (rt),
    .rd_o    (rd),
    .imm_o   (imm_ext)
  );

  assign rf_waddr = ctrl.dst_rd ? rd : rt;
  assign rf_we    = ctrl.rf_we & run;

  rcore_regfile #(.NREG(NREG), .W(XLEN)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (wb_data),
    .ra_i    (rs),
    .rb_i    (rt),
    .rc_i    (dbg_reg_i),
    .ra_o    (rs_val),
    .rb_o    (rt_val),
    .rc_o    (dbg_reg_o)
  );

  assign op_b = ctrl.use_imm ? imm_ext : rt_val;

  rcore_alu #(.W(XLEN)) i_alu (
    .op_i (ctrl.alu_op),
    .a_i  (rs_val),
    .b_i  (op_b),
    .y_o  (alu_res)
  );

  // data memory: preload port wins over core stores
  assign core_st  = ctrl.mem_we & run;
  assign dm_we    = dmem_we_i | core_st;
  assign dm_wa    = dmem_we_i ? dmem_waddr_i : alu_res[DMEM_AW+1:2];
  assign dm_wd    = dmem_we_i ? dmem_wdata_i : rt_val;
  assign dm_ra[0] = alu_res[DMEM_AW+1:2];
  assign dm_ra[1] = dbg_mem_i;
  assign dbg_mem_o = dm_rd[1];

  rcore_mem #(.AW(DMEM_AW), .W(32), .NRP(2)) i_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_wa),
    .wdata_i (dm_wd),
    .raddr_i (dm_ra),
    .rdata_o (dm_rd)
  );

  assign wb_data = ctrl.mem_to_rf ? dm_rd[0] : alu_res;

  // next pc, byte offset taken unshifted
  assign pc_plus4 = pc_q + XLEN'(4);
  assign take     = ctrl.branch && (rs_val == '0);
  assign pc_next  = take ? pc_plus4 + imm_ext : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (ctrl.halt) halted_q <= 1'b1;
      else           pc_q     <= pc_next;
    end
  end

  assign halted_o = halted_q;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IMEM_AW+2],
                         alu_res[1:0], alu_res[XLEN-1:DMEM_AW+2]};

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q);

  p_halt_pc_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> $stable(pc_q));

  p_seq_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_q && !ctrl.halt && !ctrl.branch) |=> (pc_q == $past(pc_q) + 32'd4));

  p_branch_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_q && ctrl.branch && rs_val == '0) |=>
      (pc_q == $past(pc_q) + 32'd4 + $past(imm_ext)));

  p_sub_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.alu_op == ALU_SUB) |-> (alu_res + op_b == rs_val));

  p_ctrl_class_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl.rf_we, ctrl.mem_we, ctrl.branch, ctrl.halt}));

  p_r0_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_reg_i == 5'd0) |-> (dbg_reg_o == '0));

endmodule

// File: tb/test_rcore_top.sv
module test_rcore_top;

  localparam int IMEM_AW = 6;
  localparam int DMEM_AW = 6;
  localparam int NPROG   = 38;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [10:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(6'h08, 0, 1, 5),            // 0  addi r1=5
    enc_i(6'h08, 0, 2, -3),           // 1  addi r2=-3
    enc_r(1, 2, 3, 11'h020),          // 2  add
    enc_r(1, 2, 4, 11'h022),          // 3  sub
    enc_i(6'h08, 0, 5, 32'h7FFF),     // 4
    enc_r(5, 1, 6, 11'h004),          // 5  sll by 5
    enc_i(6'h08, 0, 7, -28),          // 6
    enc_r(2, 7, 8, 11'h006),          // 7  srl by 4
    enc_r(2, 5, 9, 11'h024),          // 8  and
    enc_r(1, 6, 10, 11'h025),         // 9  or
    enc_i(6'h08, 0, 13, 1),           // 10
    enc_i(6'h08, 0, 14, 31),          // 11
    enc_r(13, 14, 15, 11'h004),       // 12 0x80000000
    enc_r(15, 13, 16, 11'h022),       // 13 overflow wrap
    enc_r(16, 13, 17, 11'h020),       // 14 overflow wrap
    enc_i(6'h08, 0, 20, 16),          // 15
    enc_i(6'h2B, 20, 4, 4),           // 16 sw r4 -> word 5
    enc_i(6'h2B, 20, 8, -4),          // 17 sw r8 -> word 3
    enc_i(6'h23, 20, 21, 4),          // 18 lw word 5
    enc_i(6'h23, 20, 22, -16),        // 19 lw word 0
    enc_i(6'h08, 0, 0, 7),            // 20 write r0
    enc_r(0, 1, 23, 11'h020),         // 21 r23 = r0 + r1
    enc_i(6'h3E, 1, 24, 32'h1234),    // 22 unknown opcode
    enc_r(1, 1, 25, 11'h3FF),         // 23 unknown func
    enc_r(1, 1, 26, 11'h420),         // 24 low bits look like add
    enc_i(6'h04, 1, 0, 8),            // 25 beqz not taken
    enc_i(6'h08, 0, 27, 1),           // 26
    enc_i(6'h04, 0, 0, 8),            // 27 beqz taken -> 30
    enc_i(6'h08, 0, 28, 99),          // 28 skipped
    enc_i(6'h08, 0, 28, 98),          // 29 skipped
    enc_i(6'h08, 0, 29, 3),           // 30
    enc_i(6'h08, 0, 30, 3),           // 31
    enc_i(6'h08, 30, 30, -1),         // 32 loop
    enc_i(6'h08, 31, 31, 2),          // 33
    enc_i(6'h04, 30, 0, 4),           // 34 exit -> 36
    enc_i(6'h04, 0, 0, -16),          // 35 back -> 32
    {6'h3F, 26'd0},                   // 36 halt
    enc_i(6'h08, 0, 24, 77)           // 37 must not run
  };

  localparam logic [31:0] EXP_RF [32] = '{
    32'h0, 32'h5, 32'hFFFFFFFD, 32'h2, 32'h8, 32'h7FFF, 32'h000FFFE0, 32'hFFFFFFE4,
    32'h0FFFFFFF, 32'h7FFD, 32'h000FFFE5, 32'h0, 32'h0, 32'h1, 32'h1F, 32'h80000000,
    32'h7FFFFFFF, 32'h80000000, 32'h0, 32'h0, 32'h10, 32'h8, 32'hA5A50001, 32'h5,
    32'h0, 32'h0, 32'h0, 32'h1, 32'h0, 32'h3, 32'h0, 32'h6
  };

  function automatic string req_of(input int r);
    case (r)
      0, 23:              return "R8";
      2, 3, 4, 16, 17:    return "R2";
      6, 8, 15:           return "R4";
      9, 10:              return "R3";
      20, 21, 22:         return "R6";
      24, 25, 26:         return "R10";
      27, 28, 29, 30, 31: return "R7";
      default:            return "R5";
    endcase
  endfunction

  logic               clk = 1'b0;
  logic               rst_ni;
  logic               imem_we;
  logic [IMEM_AW-1:0] imem_waddr;
  logic [31:0]        imem_wdata;
  logic               dmem_we;
  logic [DMEM_AW-1:0] dmem_waddr;
  logic [31:0]        dmem_wdata;
  logic [4:0]         dbg_reg;
  logic [31:0]        dbg_reg_q;
  logic [DMEM_AW-1:0] dbg_mem;
  logic [31:0]        dbg_mem_q;
  logic               halted;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  rcore_top #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) i_rcore_top (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_we_i    (imem_we),
    .imem_waddr_i (imem_waddr),
    .imem_wdata_i (imem_wdata),
    .dmem_we_i    (dmem_we),
    .dmem_waddr_i (dmem_waddr),
    .dmem_wdata_i (dmem_wdata),
    .dbg_reg_i    (dbg_reg),
    .dbg_reg_o    (dbg_reg_q),
    .dbg_mem_i    (dbg_mem),
    .dbg_mem_o    (dbg_mem_q),
    .halted_o     (halted)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_imem(input int idx, input logic [31:0] w);
    @(negedge clk);
    imem_we = 1'b1; imem_waddr = IMEM_AW'(idx); imem_wdata = w;
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic load_dmem(input int idx, input logic [31:0] w);
    @(negedge clk);
    dmem_we = 1'b1; dmem_waddr = DMEM_AW'(idx); dmem_wdata = w;
    @(negedge clk);
    dmem_we = 1'b0;
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    dbg_reg = 5'(r); #1; v = dbg_reg_q;
  endtask

  task automatic rd_mem(input int a, output logic [31:0] v);
    dbg_mem = DMEM_AW'(a); #1; v = dbg_mem_q;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected halt");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_ni = 1'b0; imem_we = 1'b0; dmem_we = 1'b0;
    imem_waddr = '0; imem_wdata = '0; dmem_waddr = '0; dmem_wdata = '0;
    dbg_reg = '0; dbg_mem = '0;

    for (int i = 0; i < (1 << IMEM_AW); i++) load_imem(i, (i < NPROG) ? PROG[i] : 32'h0);
    for (int i = 0; i < (1 << DMEM_AW); i++) load_dmem(i, (i == 0) ? 32'hA5A50001 : 32'hDEAD0000 + i);

    // R1 reset state
    check("R1", "halted in reset", {31'd0, halted}, 32'd0);
    rd_reg(5, v); check("R1", "reg5 in reset", v, 32'd0);

    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 300 && !halted; i++) @(negedge clk);
    check("R9", "halted after program", {31'd0, halted}, 32'd1);
    repeat (4) @(negedge clk);
    check("R9", "halted stays", {31'd0, halted}, 32'd1);

    // vector table of final register values
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      check(req_of(r), $sformatf("reg%0d", r), v, EXP_RF[r]);
    end

    rd_mem(5, v); check("R6", "mem word5 from sw", v, 32'h8);
    rd_mem(3, v); check("R6", "mem word3 from sw neg offset", v, 32'h0FFFFFFF);
    rd_mem(0, v); check("R6", "mem word0 untouched", v, 32'hA5A50001);
    rd_mem(4, v); check("R6", "mem word4 untouched", v, 32'hDEAD0004);

    // directed: halt at address 0, exact cycle
    @(negedge clk); rst_ni = 1'b0;
    load_imem(0, {6'h3F, 26'd0});
    load_imem(1, enc_i(6'h08, 0, 1, 9));
    rd_reg(1, v); check("R1", "regs cleared by reset", v, 32'd0);
    rd_mem(5, v); check("R1", "memory survives reset", v, 32'h8);
    @(negedge clk); rst_ni = 1'b1; #1;
    check("R1", "halted low after release", {31'd0, halted}, 32'd0);
    @(negedge clk);
    check("R9", "halted one edge after release", {31'd0, halted}, 32'd1);
    repeat (3) @(negedge clk);
    rd_reg(1, v); check("R9", "no execution after halt", v, 32'd0);

    // directed: store then halt on third edge
    @(negedge clk); rst_ni = 1'b0;
    load_imem(0, enc_i(6'h08, 0, 1, -1));
    load_imem(1, enc_i(6'h2B, 0, 1, 0));
    load_imem(2, {6'h3F, 26'd0});
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9", "not halted before third edge", {31'd0, halted}, 32'd0);
    @(negedge clk);
    check("R9", "halted at third edge", {31'd0, halted}, 32'd1);
    rd_mem(0, v); check("R6", "sw at base zero", v, 32'hFFFFFFFF);
    rd_reg(1, v); check("R5", "addi minus one", v, 32'hFFFFFFFF);

    finish_run();
  end

endmodule